// File: doc/BRIEF.md
# Inner Label Ethertype Classifier

This block watches the inner part of a routed data frame, one byte per accepted beat, on its way through the transit and egress path. It counts past the inner destination and source MAC addresses and reads the ethertype that follows. Three outcomes are possible. The frame is a coarse VLAN-labelled frame, a fine-grained-labelled frame carrying a 24-bit label split into two 12-bit halves, or a frame to be refused. From the recognised formats it extracts the transport priority, the drop-eligible bit and the label. It also forms a flow key that a downstream multipath hash can consume.

The transport priority and drop-eligible bit sit in the same four bits for both formats: the top of the word after the first ethertype. The block never reads any byte past an ethertype it does not recognise. A refused frame therefore cannot be misread as some VLAN by accident. A configuration input restricts the block to VLAN-only operation, and in that mode every fine-grained frame is marked for discard.

Top module: `fgl_inner_label_parser`

## Requirements
- R1: After reset, res_valid, res_class, res_label, res_prio, res_dei, res_discard and res_flow_key are all zero.
- R2: The first byte of a frame is the beat with in_sof. Bytes 12 and 13 form the first ethertype, high byte first. A value of 0x8100 gives class code 0 (VLAN). The label is then zero in bits 23:12, and bits 11:0 of the word at bytes 14-15 fill bits 11:0. res_discard stays 0, and res_valid rises one cycle after byte 15 is accepted.
- R3: If the first ethertype is 0x893B and the word at bytes 16-17 is also 0x893B, the class code is 1 (fine). The label is bits 11:0 of the word at bytes 14-15 (upper half) followed by bits 11:0 of the word at bytes 18-19 (lower half). res_valid rises one cycle after byte 19.
- R4: For both VLAN and fine frames, res_prio is bits 15:13 and res_dei is bit 12 of the word at bytes 14-15.
- R5: Any other first ethertype gives class code 2 (unknown), with res_discard 1 and label, priority and drop bit all zero. res_valid rises one cycle after byte 13, and no later byte of that frame changes any output.
- R6: A fine frame whose word at bytes 16-17 is not 0x893B gives class code 3 (malformed), with res_discard 1 and label, priority and drop bit zero. res_valid rises one cycle after byte 17.
- R7: A frame whose in_eof beat arrives before its classification completes gives class code 3 with res_discard 1. res_valid rises one cycle after that last byte.
- R8: When cfg_vlan_only is 1 at byte 13, a fine frame still reports class 1 and its fields but with res_discard 1. VLAN frames keep res_discard 0.
- R9: res_flow_key is {fine bit, 24-bit label, destination MAC, source MAC}, where the fine bit is 1 only for class 1 and frame byte 0 is the key's most significant MAC byte. Fine frames that differ only in the label's upper half get different keys.
- R10: Once res_valid is high, all result outputs hold until the next in_sof beat. res_valid falls the cycle after that beat. Cycles with in_valid low are ignored, so idle gaps inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vlan_only | input | 1 | Refuse fine-grained frames |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | Beat is byte 0 of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| res_valid | output | 1 | Classification results valid |
| res_class | output | 2 | 0 VLAN, 1 fine, 2 unknown, 3 malformed |
| res_label | output | 24 | Extracted label |
| res_prio | output | 3 | Transport priority |
| res_dei | output | 1 | Drop-eligible bit |
| res_discard | output | 1 | Frame must be dropped |
| res_flow_key | output | 121 | Multipath flow key fields |

## Verification
The bench builds the block with its defaults: 6-byte MAC fields, 12-bit label halves and a two-stage reset synchroniser. With these defaults the decision points fall on bytes 13, 15, 17 and 19, and the full 24-bit label appears in the key. Directed frames land on each decision byte and on truncations one byte short of it. They include an unknown-ethertype frame whose payload mimics a VLAN tag, and a frame with idle gaps. The valid strobe is sampled on both sides of each decision edge, so the one-cycle latency is checked exactly.

// File: rtl/fgl_pkg.sv
package fgl_pkg;
  typedef enum logic [1:0] {
    CLS_VLAN      = 2'd0,
    CLS_FINE      = 2'd1,
    CLS_UNKNOWN   = 2'd2,
    CLS_MALFORMED = 2'd3
  } lbl_class_e;

  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  localparam logic [15:0] ETYPE_FINE = 16'h893B;
  localparam int PRIO_W = 3;
endpackage

// File: rtl/fgl_pos_counter.sv
module fgl_pos_counter #(
  parameter int MAX_POS = 19,
  localparam int POS_W = $clog2(MAX_POS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] SAT = POS_W'(MAX_POS + 1);

  logic [POS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (beat) begin
      if (sof) cnt_d = POS_W'(1);
      else if (cnt_q != SAT) cnt_d = cnt_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pos = sof ? '0 : cnt_q;
endmodule

// File: rtl/fgl_hdr_capture.sv
module fgl_hdr_capture #(
  parameter int HDR_BYTES = 12,
  parameter int W1_POS    = 15,
  parameter int POS_W     = 5,
  localparam int MAC_W    = HDR_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [POS_W-1:0] pos,
  input  logic [7:0]       data,
  output logic [15:0]      word,
  output logic [15:0]      w1,
  output logic [MAC_W-1:0] macs
);
  logic [MAC_W-1:0] mac_q, mac_d;
  logic [7:0]       hi_q, hi_d;
  logic [15:0]      w1_q, w1_d;

  assign word = {hi_q, data};

  always_comb begin
    mac_d = mac_q;
    hi_d  = hi_q;
    w1_d  = w1_q;
    if (beat) begin
      hi_d = data;
      if (pos < POS_W'(HDR_BYTES)) mac_d = {mac_q[MAC_W-9:0], data};
      if (pos == POS_W'(W1_POS))   w1_d  = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q <= '0;
      hi_q  <= '0;
      w1_q  <= '0;
    end else begin
      mac_q <= mac_d;
      hi_q  <= hi_d;
      w1_q  <= w1_d;
    end
  end

  assign w1   = w1_q;
  assign macs = mac_q;
endmodule

// File: rtl/fgl_label_classifier.sv
module fgl_label_classifier
  import fgl_pkg::*;
#(
  parameter int POS_W    = 5,
  parameter int ETH_POS  = 13,
  parameter int W1_POS   = 15,
  parameter int ETH2_POS = 17,
  parameter int W2_POS   = 19,
  parameter int PART_W   = 12,
  localparam int LBL_W   = 2 * PART_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sof,
  input  logic              eof,
  input  logic [POS_W-1:0]  pos,
  input  logic [15:0]       word,
  input  logic [15:0]       w1,
  input  logic              vlan_only,
  output logic              res_valid,
  output lbl_class_e        res_class,
  output logic [LBL_W-1:0]  res_label,
  output logic [PRIO_W-1:0] res_prio,
  output logic              res_dei,
  output logic              res_discard
);
  logic              active_q, active_d;
  logic              fine_q, fine_d;
  logic              refuse_q, refuse_d;
  logic              valid_q, valid_d;
  lbl_class_e        cls_q, cls_d;
  logic [LBL_W-1:0]  lbl_q, lbl_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              dei_q, dei_d;
  logic              disc_q, disc_d;

  logic              fin;
  lbl_class_e        f_cls;
  logic [LBL_W-1:0]  f_lbl;
  logic [PRIO_W-1:0] f_prio;
  logic              f_dei;
  logic              f_disc;

  always_comb begin
    active_d = active_q;
    fine_d   = fine_q;
    refuse_d = refuse_q;
    valid_d  = valid_q;
    cls_d    = cls_q;
    lbl_d    = lbl_q;
    prio_d   = prio_q;
    dei_d    = dei_q;
    disc_d   = disc_q;
    fin      = 1'b0;
    f_cls    = CLS_MALFORMED;
    f_lbl    = '0;
    f_prio   = '0;
    f_dei    = 1'b0;
    f_disc   = 1'b1;
    if (beat) begin
      if (sof) begin
        active_d = 1'b1;
        valid_d  = 1'b0;
      end
      if (sof || active_q) begin
        if (pos == POS_W'(ETH_POS)) begin
          if (word == ETYPE_VLAN) begin
            fine_d = 1'b0;
          end else if (word == ETYPE_FINE) begin
            fine_d   = 1'b1;
            refuse_d = vlan_only;
          end else begin
            fin   = 1'b1;
            f_cls = CLS_UNKNOWN;
          end
        end else if (pos == POS_W'(W1_POS)) begin
          if (!fine_q) begin
            fin    = 1'b1;
            f_cls  = CLS_VLAN;
            f_lbl  = {{PART_W{1'b0}}, word[PART_W-1:0]};
            f_prio = word[15:13];
            f_dei  = word[12];
            f_disc = 1'b0;
          end
        end else if (pos == POS_W'(ETH2_POS)) begin
          if (word != ETYPE_FINE) begin
            fin   = 1'b1;
            f_cls = CLS_MALFORMED;
          end
        end else if (pos == POS_W'(W2_POS)) begin
          fin    = 1'b1;
          f_cls  = CLS_FINE;
          f_lbl  = {w1[PART_W-1:0], word[PART_W-1:0]};
          f_prio = w1[15:13];
          f_dei  = w1[12];
          f_disc = refuse_q;
        end
        if (!fin && eof) begin
          fin   = 1'b1;
          f_cls = CLS_MALFORMED;
        end
        if (fin) begin
          active_d = 1'b0;
          valid_d  = 1'b1;
          cls_d    = f_cls;
          lbl_d    = f_lbl;
          prio_d   = f_prio;
          dei_d    = f_dei;
          disc_d   = f_disc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fine_q   <= 1'b0;
      refuse_q <= 1'b0;
      valid_q  <= 1'b0;
      cls_q    <= CLS_VLAN;
      lbl_q    <= '0;
      prio_q   <= '0;
      dei_q    <= 1'b0;
      disc_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      fine_q   <= fine_d;
      refuse_q <= refuse_d;
      valid_q  <= valid_d;
      cls_q    <= cls_d;
      lbl_q    <= lbl_d;
      prio_q   <= prio_d;
      dei_q    <= dei_d;
      disc_q   <= disc_d;
    end
  end

  assign res_valid   = valid_q;
  assign res_class   = cls_q;
  assign res_label   = lbl_q;
  assign res_prio    = prio_q;
  assign res_dei     = dei_q;
  assign res_discard = disc_q;
endmodule

// File: rtl/fgl_inner_label_parser.sv
module fgl_inner_label_parser
  import fgl_pkg::*;
#(
  parameter int MAC_BYTES   = 6,
  parameter int PART_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int HDR_BYTES  = 2 * MAC_BYTES,
  localparam int LBL_W      = 2 * PART_W,
  localparam int MAC_W      = HDR_BYTES * 8,
  localparam int KEY_W      = 1 + LBL_W + MAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_vlan_only,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             res_valid,
  output logic [1:0]       res_class,
  output logic [LBL_W-1:0] res_label,
  output logic [2:0]       res_prio,
  output logic             res_dei,
  output logic             res_discard,
  output logic [KEY_W-1:0] res_flow_key
);
  localparam int ETH_POS  = HDR_BYTES + 1;
  localparam int W1_POS   = HDR_BYTES + 3;
  localparam int ETH2_POS = HDR_BYTES + 5;
  localparam int W2_POS   = HDR_BYTES + 7;
  localparam int POS_W    = $clog2(W2_POS + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   core_rst_n;
  logic                   beat;
  logic [POS_W-1:0]       pos;
  logic [15:0]            word, w1;
  logic [MAC_W-1:0]       macs;
  lbl_class_e             cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = sync_q[SYNC_STAGES-1];

  assign beat = in_valid;

  fgl_pos_counter #(.MAX_POS(W2_POS)) u_pos (
    .clk   (clk),
    .rst_n (core_rst_n),
    .beat  (beat),
    .sof   (in_sof),
    .pos   (pos)
  );

  fgl_hdr_capture #(
    .HDR_BYTES (HDR_BYTES),
    .W1_POS    (W1_POS),
    .POS_W     (POS_W)
  ) u_cap (
    .clk   (clk),
    .rst_n (core_rst_n),
    .beat  (beat),
    .pos   (pos),
    .data  (in_data),
    .word  (word),
    .w1    (w1),
    .macs  (macs)
  );

  fgl_label_classifier #(
    .POS_W    (POS_W),
    .ETH_POS  (ETH_POS),
    .W1_POS   (W1_POS),
    .ETH2_POS (ETH2_POS),
    .W2_POS   (W2_POS),
    .PART_W   (PART_W)
  ) u_cls (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .beat        (beat),
    .sof         (in_sof),
    .eof         (in_eof),
    .pos         (pos),
    .word        (word),
    .w1          (w1),
    .vlan_only   (cfg_vlan_only),
    .res_valid   (res_valid),
    .res_class   (cls),
    .res_label   (res_label),
    .res_prio    (res_prio),
    .res_dei     (res_dei),
    .res_discard (res_discard)
  );

  assign res_class    = cls;
  assign res_flow_key = {cls == CLS_FINE, res_label, macs};
endmodule

// File: rtl/fgl_inner_label_parser_chk.sv
module fgl_inner_label_parser_chk #(
  parameter int LBL_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic             res_valid,
  input logic [1:0]       res_class,
  input logic [LBL_W-1:0] res_label,
  input logic [2:0]       res_prio,
  input logic             res_dei,
  input logic             res_discard
);
  AST_VLAN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == 2'd0) |-> (res_label[LBL_W-1:LBL_W/2] == '0 && !res_discard)); // R2

  AST_REFUSED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == 2'd2) |-> res_discard); // R5

  AST_REFUSED_NO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class[1]) |-> (res_label == '0 && res_prio == 3'd0 && !res_dei && res_discard)); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> ($stable(res_class) && $stable(res_label) &&
                                         $stable(res_prio) && $stable(res_dei) && $stable(res_discard))); // R10

  AST_VALID_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid)); // R10

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof) |=> !res_valid); // R10
endmodule

bind fgl_inner_label_parser fgl_inner_label_parser_chk #(.LBL_W(LBL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sof      (in_sof),
  .in_eof      (in_eof),
  .res_valid   (res_valid),
  .res_class   (res_class),
  .res_label   (res_label),
  .res_prio    (res_prio),
  .res_dei     (res_dei),
  .res_discard (res_discard)
);

// File: tb/fgl_inner_label_parser_tb.sv
module fgl_inner_label_parser_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_vlan_only = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_sof = 1'b0;
  logic         in_eof = 1'b0;
  logic [7:0]   in_data = 8'h00;
  logic         res_valid;
  logic [1:0]   res_class;
  logic [23:0]  res_label;
  logic [2:0]   res_prio;
  logic         res_dei;
  logic         res_discard;
  logic [120:0] res_flow_key;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]  fr [0:31];
  logic        vs [0:32];
  logic [1:0]  cs [0:32];
  logic [23:0] ls [0:32];
  logic        ds [0:32];

  localparam logic [47:0] DA = 48'h001122334455;
  localparam logic [47:0] SA = 48'h66778899AABB;

  always #5 clk = ~clk;

  fgl_inner_label_parser u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_vlan_only (cfg_vlan_only),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_data       (in_data),
    .res_valid     (res_valid),
    .res_class     (res_class),
    .res_label     (res_label),
    .res_prio      (res_prio),
    .res_dei       (res_dei),
    .res_discard   (res_discard),
    .res_flow_key  (res_flow_key)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mk_hdr(input logic [15:0] eth1, input logic [15:0] wa,
                        input logic [15:0] eth2, input logic [15:0] wb);
    for (int i = 0; i < 6; i++) begin
      fr[i]   = DA[47-8*i -: 8];
      fr[6+i] = SA[47-8*i -: 8];
    end
    fr[12] = eth1[15:8]; fr[13] = eth1[7:0];
    fr[14] = wa[15:8];   fr[15] = wa[7:0];
    fr[16] = eth2[15:8]; fr[17] = eth2[7:0];
    fr[18] = wb[15:8];   fr[19] = wb[7:0];
    for (int i = 20; i < 32; i++) fr[i] = 8'(8'hC0 + i);
  endtask

  task automatic run_frame(input int len, input bit gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gap && i > 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      vs[i] = res_valid; cs[i] = res_class; ls[i] = res_label; ds[i] = res_discard;
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = fr[i];
    end
    @(negedge clk);
    vs[len] = res_valid; cs[len] = res_class; ls[len] = res_label; ds[len] = res_discard;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_timing(input int dpos, input int len, input string req);
    if (dpos > 0) chk(vs[dpos] == 1'b0, req, 128'(vs[dpos]), 128'd0);
    chk(vs[dpos+1] == 1'b1, req, 128'(vs[dpos+1]), 128'd1);
    chk(cs[dpos+1] == res_class && ls[dpos+1] == res_label && ds[dpos+1] == res_discard,
        "R10", 128'(ls[dpos+1]), 128'(res_label));
    chk(vs[len] == 1'b1, "R10", 128'(vs[len]), 128'd1);
  endtask

  task automatic t_reset();
    chk(res_valid == 1'b0 && res_discard == 1'b0, "R1", 128'({res_valid, res_discard}), 128'd0);
    chk(res_class == 2'd0 && res_label == 24'd0 && res_prio == 3'd0 && !res_dei, "R1",
        128'(res_label), 128'd0);
    chk(res_flow_key == '0, "R1", 128'(res_flow_key), 128'd0);
  endtask

  task automatic t_vlan();
    mk_hdr(16'h8100, 16'hB5A7, 16'h1234, 16'h5678);
    run_frame(22, 1'b0);
    chk_timing(15, 22, "R2");
    chk(res_class == 2'd0 && res_discard == 1'b0, "R2", 128'({res_class, res_discard}), 128'd0);
    chk(res_label == 24'h0005A7, "R2", 128'(res_label), 128'h5A7);
    chk(res_prio == 3'd5 && res_dei == 1'b1, "R4", 128'({res_prio, res_dei}), 128'hB);
    chk(res_flow_key == {1'b0, 24'h0005A7, DA, SA}, "R9", 128'(res_flow_key),
        128'({1'b0, 24'h0005A7, DA, SA}));
  endtask

  task automatic t_fine();
    logic [120:0] k1;
    mk_hdr(16'h893B, 16'h6ABC, 16'h893B, 16'hF123);
    run_frame(24, 1'b0);
    chk_timing(19, 24, "R3");
    chk(res_class == 2'd1 && res_discard == 1'b0, "R3", 128'({res_class, res_discard}), 128'h2);
    chk(res_label == 24'hABC123, "R3", 128'(res_label), 128'hABC123);
    chk(res_prio == 3'd3 && res_dei == 1'b0, "R4", 128'({res_prio, res_dei}), 128'h6);
    chk(res_flow_key == {1'b1, 24'hABC123, DA, SA}, "R9", 128'(res_flow_key),
        128'({1'b1, 24'hABC123, DA, SA}));
    k1 = res_flow_key;
    mk_hdr(16'h893B, 16'h6ABD, 16'h893B, 16'hF123);
    run_frame(20, 1'b0);
    chk(res_label == 24'hABD123 && res_flow_key != k1, "R9", 128'(res_flow_key), 128'(k1));
  endtask

  task automatic t_unknown();
    mk_hdr(16'h0800, 16'h8100, 16'h3456, 16'h8100);
    run_frame(22, 1'b0);
    chk_timing(13, 22, "R5");
    chk(res_class == 2'd2 && res_discard == 1'b1, "R5", 128'({res_class, res_discard}), 128'h5);
    chk(res_label == 24'd0 && res_prio == 3'd0 && !res_dei, "R5", 128'(res_label), 128'd0);
  endtask

  task automatic t_bad_second();
    mk_hdr(16'h893B, 16'hE111, 16'h8100, 16'h0222);
    run_frame(22, 1'b0);
    chk_timing(17, 22, "R6");
    chk(res_class == 2'd3 && res_discard == 1'b1 && res_label == 24'd0 && res_prio == 3'd0,
        "R6", 128'({res_class, res_discard, res_label}), 128'({2'd3, 1'b1, 24'd0}));
  endtask

  task automatic t_truncated();
    mk_hdr(16'h893B, 16'h2001, 16'h893B, 16'h0002);
    run_frame(19, 1'b0);
    chk_timing(18, 19, "R7");
    chk(res_class == 2'd3 && res_discard == 1'b1, "R7", 128'({res_class, res_discard}), 128'h7);
    mk_hdr(16'h8100, 16'h0042, 16'h0, 16'h0);
    run_frame(15, 1'b0);
    chk_timing(14, 15, "R7");
    chk(res_class == 2'd3 && res_discard == 1'b1, "R7", 128'({res_class, res_discard}), 128'h7);
    run_frame(1, 1'b0);
    chk(vs[1] == 1'b1 && res_class == 2'd3 && res_discard == 1'b1, "R7",
        128'({vs[1], res_class, res_discard}), 128'hF);
  endtask

  task automatic t_vlan_only();
    cfg_vlan_only = 1'b1;
    mk_hdr(16'h893B, 16'h0777, 16'h893B, 16'h0888);
    run_frame(20, 1'b0);
    chk(res_valid && res_class == 2'd1 && res_discard == 1'b1, "R8",
        128'({res_valid, res_class, res_discard}), 128'hB);
    chk(res_label == 24'h777888, "R8", 128'(res_label), 128'h777888);
    mk_hdr(16'h8100, 16'h0010, 16'h0, 16'h0);
    run_frame(18, 1'b0);
    chk(res_class == 2'd0 && res_discard == 1'b0 && res_label == 24'h10, "R8",
        128'({res_class, res_discard, res_label}), 128'h10);
    cfg_vlan_only = 1'b0;
  endtask

  task automatic t_gaps();
    mk_hdr(16'h8100, 16'h4FED, 16'h0, 16'h0);
    run_frame(18, 1'b1);
    chk(res_valid && res_class == 2'd0 && res_label == 24'h000FED && res_prio == 3'd2,
        "R10", 128'(res_label), 128'hFED);
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h00;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk(res_valid == 1'b0, "R10", 128'(res_valid), 128'd0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_vlan();
    t_fine();
    t_unknown();
    t_bad_second();
    t_truncated();
    t_vlan_only();
    t_gaps();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule